// File: doc/BRIEF.md
# Receive Page Ring Manager

This block places incoming receive frames into a circular buffer built from fixed pages. A page holds 2^OFF_W bytes (256 with the default OFF_W of 8) and is named by its PAGE_W-bit page number alone. The host programs a first page, a limit page and a boundary page. The boundary page marks where the host has not yet finished reading. The block keeps the current write page. Each new frame starts there, with the payload placed after a four-byte header area. When the frame ends, the header is filled in with a status byte, the page where the following frame will begin, and the payload byte count.

Before every step onto a new page, the block checks the step against the boundary page. If the step would land on the boundary, the frame is abandoned and a sticky overflow flag is raised. The flag drops by itself once the host moves the boundary away from the value it held when the overflow occurred. Frames that arrive while the flag is high are not stored. Each abandoned or refused frame raises a one-cycle miss pulse and bumps a saturating tally counter.

Payload bytes enter on a valid/ready stream. Ready is high only while a frame is open, and low in the same cycle as the frame-end strobe. Ready is also low while idle and while the header bytes are written. A byte is taken on a rising clock edge where valid and ready are both high. While ready is low, the sender holds its byte. Frame start and frame end are single-cycle strobes. A frame start is acted on only when idle. A frame end is acted on only while a frame is open.

Top module: `ring_rx_mgr`

## Requirements
- R1: Payload byte k of a stored frame is written, in the same cycle it is accepted, to address page*2^OFF_W + 4 + k. Bytes run upward within a page and continue at offset 0 of the next page. The address is {page, offset}, and the written data equals the input byte.
- R2: The page after page p is p+1 (modulo 2^PAGE_W), unless p+1 equals the limit page, in which case it is the first page.
- R3: If accepting a byte that fills a page, or closing a frame whose last page is partly used, would step onto the boundary page, the frame is abandoned. The remaining bytes are accepted but not written, no header is written, the overflow flag is set, and the next-packet page is unchanged.
- R4: The overflow flag is high after reset and records the boundary page when set. It clears one cycle after the boundary input differs from that recorded value (the recorded value is 0 after reset).
- R5: A frame start while the overflow flag is high stores nothing. Every refused or abandoned frame produces exactly one one-cycle miss pulse and one tally increment.
- R6: The tally is 0 after reset and saturates at 2^TALLY_W-1. The half-full output equals its top bit.
- R7: After an accepted frame end, four header bytes are written in four consecutive cycles, with ready low, to offsets 0,1,2,3 of the frame's first page. They hold, in that order: the frame status byte, the next-packet page, the count low byte and the count high byte.
- R8: After the header, the next-packet page output becomes the page after the frame's last used page, or that page itself when the frame ended exactly on a page end.
- R9: After reset, ready and write enable are low. Ready is high only while a frame is open and frame end is not asserted.
- R10: A current-page write while idle loads the next-packet page output on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_page | input | PAGE_W | First page of the ring |
| limit_page | input | PAGE_W | Page just past the ring's end |
| bnd_page | input | PAGE_W | Host read boundary page |
| cur_wr | input | 1 | Load strobe for the current write page |
| cur_wr_page | input | PAGE_W | Value loaded by cur_wr |
| frame_start | input | 1 | Frame begins (one cycle) |
| frame_end | input | 1 | Frame ends (one cycle) |
| frame_status | input | 8 | Status byte stored in the header |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | DATA_W | Payload byte |
| in_ready | output | 1 | Block can take a byte |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | PAGE_W+OFF_W | Buffer write address |
| mem_data | output | DATA_W | Buffer write data |
| next_pkt_page | output | PAGE_W | Page where the next frame begins |
| rx_ovf | output | 1 | Sticky overflow flag |
| rx_miss | output | 1 | One-cycle missed-frame pulse |
| miss_tally | output | TALLY_W | Saturating missed-frame count |
| tally_half | output | 1 | Top bit of the tally |

## Verification
The bench sweeps frame lengths from empty up to several pages over four rings. One ring wraps through page 0xFF back to its first page, and one ring has only two pages, so every frame in it collides with the boundary. A design that compared against the wrong page when wrapping would write outside the ring. A design that checked the boundary one byte late would let a frame overwrite unread data. A design that also tested the step at an exact page end would reject frames that fit. Skipped host updates force overflows both mid-frame and at frame end. A flag that cleared without a boundary change, or never cleared, shows up as stored or refused frames the arithmetic model does not predict. A long run of refused frames pushes the tally past half-full into saturation, which catches a counter that wraps.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } ring_st_e;
endpackage

// File: rtl/ring_page_step.sv
// Successor of a page inside the ring, wrapping at the limit page.
module ring_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur,
  input  logic [PAGE_W-1:0] first,
  input  logic [PAGE_W-1:0] limit,
  output logic [PAGE_W-1:0] nxt
);
  logic [PAGE_W-1:0] inc;
  always_comb begin
    inc = cur + 1'b1;
    nxt = (inc == limit) ? first : inc;
  end
endmodule

// File: rtl/ring_tally.sv
// Saturating event counter with a half-full indication.
module ring_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] cnt,
  output logic         half
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (bump && (cnt != {W{1'b1}}))
      cnt <= cnt + 1'b1;
  end
  assign half = cnt[W-1];
endmodule

// File: rtl/ring_ovf_track.sv
// Sticky overflow flag that releases once the boundary moves.
module ring_ovf_track #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [PAGE_W-1:0] bnd,
  output logic              ovf,
  output logic [PAGE_W-1:0] bnd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf   <= 1'b1;
      bnd_q <= '0;
    end else if (set) begin
      ovf   <= 1'b1;
      bnd_q <= bnd;
    end else if (ovf && (bnd != bnd_q)) begin
      ovf   <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_hdr_sel.sv
// Selects the header byte for a given header slot.
module ring_hdr_sel #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  parameter int HIDX_W = 2
) (
  input  logic [HIDX_W-1:0] idx,
  input  logic [7:0]        status,
  input  logic [PAGE_W-1:0] nxt,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] hbyte
);
  logic [CNT_W-1:0] shifted;
  always_comb begin
    shifted = '0;
    hbyte   = '0;
    if (idx == HIDX_W'(0)) begin
      hbyte = DATA_W'(status);
    end else if (idx == HIDX_W'(1)) begin
      hbyte = DATA_W'(nxt);
    end else begin
      shifted = cnt >> (DATA_W * (32'(idx) - 32'd2));
      hbyte   = shifted[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/ring_rx_mgr.sv
module ring_rx_mgr
  import ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int TALLY_W   = 8,
  parameter int HDR_BYTES = 4,
  localparam int ADDR_W   = PAGE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAGE_W-1:0]  first_page,
  input  logic [PAGE_W-1:0]  limit_page,
  input  logic [PAGE_W-1:0]  bnd_page,
  input  logic               cur_wr,
  input  logic [PAGE_W-1:0]  cur_wr_page,
  input  logic               frame_start,
  input  logic               frame_end,
  input  logic [7:0]         frame_status,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data,
  output logic [PAGE_W-1:0]  next_pkt_page,
  output logic               rx_ovf,
  output logic               rx_miss,
  output logic [TALLY_W-1:0] miss_tally,
  output logic               tally_half
);
  localparam int HIDX_W = $clog2(HDR_BYTES);
  localparam logic [OFF_W-1:0]  OFF_MAX  = {OFF_W{1'b1}};
  localparam logic [OFF_W-1:0]  OFF_BASE = OFF_W'(HDR_BYTES);
  localparam logic [HIDX_W-1:0] HIDX_END = HIDX_W'(HDR_BYTES - 1);

  ring_st_e           state;
  logic [PAGE_W-1:0]  cur_page, frm_page, wr_page, nxt_q;
  logic [OFF_W-1:0]   wr_off;
  logic [CNT_W-1:0]   byte_cnt;
  logic [HIDX_W-1:0]  hdr_idx;
  logic [7:0]         stat_q;
  logic               miss_q;

  logic [PAGE_W-1:0]  wr_nxt, end_pg, ovf_bnd_q;
  logic [DATA_W-1:0]  hdr_byte;
  logic               take, at_edge, hits_bnd, abort_byte, end_fail, start_miss;
  logic               ovf_set, bump;

  ring_page_step #(.PAGE_W(PAGE_W)) u_step (
    .cur(wr_page), .first(first_page), .limit(limit_page), .nxt(wr_nxt)
  );

  ring_ovf_track #(.PAGE_W(PAGE_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .set(ovf_set), .bnd(bnd_page),
    .ovf(rx_ovf), .bnd_q(ovf_bnd_q)
  );

  ring_tally #(.W(TALLY_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .bump(bump), .cnt(miss_tally), .half(tally_half)
  );

  ring_hdr_sel #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .HIDX_W(HIDX_W)) u_hdr (
    .idx(hdr_idx), .status(stat_q), .nxt(nxt_q), .cnt(byte_cnt), .hbyte(hdr_byte)
  );

  // Stream and decision terms
  always_comb begin
    in_ready   = ((state == ST_RECV) || (state == ST_DROP)) && !frame_end;
    take       = (state == ST_RECV) && in_valid && !frame_end;
    at_edge    = (wr_off == OFF_MAX);
    hits_bnd   = (wr_nxt == bnd_page);
    abort_byte = take && at_edge && hits_bnd;
    end_fail   = (state == ST_RECV) && frame_end && (wr_off != '0) && hits_bnd;
    end_pg     = (wr_off == '0) ? wr_page : wr_nxt;
    start_miss = (state == ST_IDLE) && frame_start && rx_ovf;
    ovf_set    = abort_byte || end_fail;
    bump       = ovf_set || start_miss;
  end

  // Buffer write port
  always_comb begin
    mem_we   = take || (state == ST_HDR);
    if (state == ST_HDR) begin
      mem_addr = {frm_page, {(OFF_W-HIDX_W){1'b0}}, hdr_idx};
      mem_data = hdr_byte;
    end else begin
      mem_addr = {wr_page, wr_off};
      mem_data = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_page <= '0;
      frm_page <= '0;
      wr_page  <= '0;
      wr_off   <= '0;
      byte_cnt <= '0;
      hdr_idx  <= '0;
      stat_q   <= '0;
      nxt_q    <= '0;
      miss_q   <= 1'b0;
    end else begin
      miss_q <= bump;
      case (state)
        ST_IDLE: begin
          if (frame_start) begin
            if (rx_ovf) begin
              state <= ST_DROP;
            end else begin
              state    <= ST_RECV;
              frm_page <= cur_page;
              wr_page  <= cur_page;
              wr_off   <= OFF_BASE;
              byte_cnt <= '0;
            end
          end else if (cur_wr) begin
            cur_page <= cur_wr_page;
          end
        end
        ST_RECV: begin
          if (frame_end) begin
            if (end_fail) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_HDR;
              nxt_q   <= end_pg;
              stat_q  <= frame_status;
              hdr_idx <= '0;
            end
          end else if (in_valid) begin
            byte_cnt <= byte_cnt + 1'b1;
            if (at_edge) begin
              if (hits_bnd) begin
                state <= ST_DROP;
              end else begin
                wr_page <= wr_nxt;
                wr_off  <= '0;
              end
            end else begin
              wr_off <= wr_off + 1'b1;
            end
          end
        end
        ST_DROP: begin
          if (frame_end) state <= ST_IDLE;
        end
        default: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == HIDX_END) begin
            state    <= ST_IDLE;
            cur_page <= nxt_q;
          end
        end
      endcase
    end
  end

  assign next_pkt_page = cur_page;
  assign rx_miss       = miss_q;
endmodule

// File: rtl/ring_rx_chk.sv
module ring_rx_chk #(
  parameter int PAGE_W  = 8,
  parameter int TALLY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               mem_we,
  input logic               rx_ovf,
  input logic               rx_miss,
  input logic [TALLY_W-1:0] miss_tally,
  input logic [PAGE_W-1:0]  bnd_page,
  input logic [PAGE_W-1:0]  ovf_bnd_q
);
  // R6
  tally_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_tally == {TALLY_W{1'b1}}) |=> (miss_tally == {TALLY_W{1'b1}}));

  // R5
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_tally != $past(miss_tally)) |-> (rx_miss && (miss_tally == TALLY_W'($past(miss_tally) + 1'b1))));

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && (bnd_page == ovf_bnd_q)) |=> rx_ovf);

  // R3
  abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> !mem_we);

  // R7
  hdr_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !in_valid) |-> !in_ready);
endmodule

bind ring_rx_mgr ring_rx_chk #(.PAGE_W(PAGE_W), .TALLY_W(TALLY_W)) u_ring_rx_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .rx_ovf(rx_ovf), .rx_miss(rx_miss), .miss_tally(miss_tally),
  .bnd_page(bnd_page), .ovf_bnd_q(ovf_bnd_q)
);

// File: tb/tb_ring_rx_mgr.sv
module tb_ring_rx_mgr;
  localparam int OFFW = 4;
  localparam int PGSZ = 1 << OFFW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] first_pg = 8'h10, limit_pg = 8'h18, bnd_pg = 8'h00, cur_wr_pg = 8'h00;
  logic cur_wr = 1'b0, frame_start = 1'b0, frame_end = 1'b0, in_valid = 1'b0;
  logic [7:0] frame_status = 8'h00, in_data = 8'h00;
  logic in_ready, mem_we, rx_ovf, rx_miss, tally_half;
  logic [11:0] mem_addr;
  logic [7:0] mem_data, next_pkt_page, miss_tally;

  int nchk = 0, nfail = 0;
  int miss_seen = 0, bumps_m = 0;
  bit ovf_m = 1'b1;
  int obnd_m = 0, tally_m = 0, cur_m = 0;

  always #10 clk = ~clk;

  ring_rx_mgr #(.OFF_W(OFFW)) dut (
    .clk(clk), .rst_n(rst_n), .first_page(first_pg), .limit_page(limit_pg),
    .bnd_page(bnd_pg), .cur_wr(cur_wr), .cur_wr_page(cur_wr_pg),
    .frame_start(frame_start), .frame_end(frame_end), .frame_status(frame_status),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .next_pkt_page(next_pkt_page),
    .rx_ovf(rx_ovf), .rx_miss(rx_miss), .miss_tally(miss_tally), .tally_half(tally_half)
  );

  always @(negedge clk) if (rst_n && rx_miss) miss_seen++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt_m(input int p);
    int q;
    q = (p + 1) & 8'hFF;
    return (q == int'(limit_pg)) ? int'(first_pg) : q;
  endfunction

  function automatic int prev_m(input int p);
    return (p == int'(first_pg)) ? ((int'(limit_pg) - 1) & 8'hFF) : ((p - 1) & 8'hFF);
  endfunction

  task automatic bump_m();
    bumps_m++;
    if (tally_m < 255) tally_m++;
  endtask

  task automatic set_bnd(input int v);
    @(negedge clk); bnd_pg = 8'(v);
    @(negedge clk); @(negedge clk);
    if (ovf_m && v != obnd_m) ovf_m = 1'b0;
    #1 chk("R4 overflow release", rx_ovf, ovf_m);
  endtask

  task automatic load_cur(input int v);
    @(negedge clk); cur_wr = 1'b1; cur_wr_pg = 8'(v);
    @(negedge clk); cur_wr = 1'b0;
    cur_m = v;
    #1 chk("R10 current page load", next_pkt_page, cur_m);
  endtask

  task automatic send_frame(input int len);
    int pg, off, np, fp;
    bit alive, wrapped;
    string req;
    @(negedge clk);
    frame_start = 1'b1;
    frame_status = 8'(len ^ 8'h5A);
    alive = !ovf_m;
    @(negedge clk);
    frame_start = 1'b0;
    if (!alive) bump_m();
    fp = cur_m; pg = cur_m; off = 4; np = cur_m; wrapped = 1'b0;
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_data = 8'(k * 7 + len);
      #1;
      chk("R9 ready in frame", in_ready, 1);
      if (alive) begin
        req = wrapped ? "R2 wrapped address" : "R1 payload address";
        chk(req, mem_we, 1);
        chk(req, mem_addr, pg * PGSZ + off);
        chk("R1 payload data", mem_data, int'(in_data));
        if (off == PGSZ - 1) begin
          if (nxt_m(pg) == int'(bnd_pg)) begin
            alive = 1'b0; ovf_m = 1'b1; obnd_m = bnd_pg; bump_m();
          end else begin
            if (nxt_m(pg) == int'(first_pg)) wrapped = 1'b1;
            pg = nxt_m(pg); off = 0;
          end
        end else off++;
      end else begin
        chk("R3 no write after abort", mem_we, 0);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    frame_end = 1'b1;
    #1 chk("R9 ready low at end", in_ready, 0);
    if (alive) begin
      if (off == 0) np = pg;
      else begin
        np = nxt_m(pg);
        if (np == int'(bnd_pg)) begin
          alive = 1'b0; ovf_m = 1'b1; obnd_m = bnd_pg; bump_m();
        end
      end
    end
    @(negedge clk);
    frame_end = 1'b0;
    if (alive) begin
      for (int h = 0; h < 4; h++) begin
        #1;
        chk("R7 header write", mem_we, 1);
        chk("R7 header ready", in_ready, 0);
        chk("R7 header address", mem_addr, fp * PGSZ + h);
        case (h)
          0: chk("R7 header status", mem_data, (len ^ 8'h5A) & 8'hFF);
          1: chk("R7 header next page", mem_data, np);
          2: chk("R7 header count low", mem_data, len & 8'hFF);
          default: chk("R7 header count high", mem_data, (len >> 8) & 8'hFF);
        endcase
        @(negedge clk);
      end
      cur_m = np;
    end else begin
      #1 chk("R3 no header after abort", mem_we, 0);
    end
    @(negedge clk);
    #1;
    chk("R8 next packet page", next_pkt_page, cur_m);
    chk("R3 overflow flag", rx_ovf, ovf_m);
    chk("R6 tally", miss_tally, tally_m);
    chk("R6 half full", tally_half, (tally_m >> 7) & 1);
    chk("R5 miss pulses", miss_seen, bumps_m);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int cfg_first[4] = '{8'h10, 8'hFD, 8'h40, 8'h20};
    int cfg_limit[4] = '{8'h18, 8'h00, 8'h43, 8'h22};
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset overflow", rx_ovf, 1);
    chk("R6 reset tally", miss_tally, 0);
    chk("R9 reset ready", in_ready, 0);
    chk("R9 reset write", mem_we, 0);
    chk("R5 reset miss", rx_miss, 0);
    @(negedge clk); rst_n = 1'b1;
    // R5: power-up overflow refuses a frame
    send_frame(5);
    chk("R5 refused at power-up", miss_seen, 1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      first_pg = 8'(cfg_first[c]);
      limit_pg = 8'(cfg_limit[c]);
      set_bnd(cfg_first[c] ^ 8'h80);
      set_bnd(cfg_first[c]);
      load_cur(nxt_m(cfg_first[c]));
      for (int len = 0; len <= 40; len++) begin
        send_frame(len);
        if (ovf_m) begin
          set_bnd(prev_m(cur_m) ^ 8'h80);
          set_bnd(prev_m(cur_m));
        end else if ((len % 4) != 3) begin
          set_bnd(prev_m(cur_m));
        end
      end
    end
    // R6: two-page ring keeps overflowing; drive the tally to saturation
    set_bnd(int'(first_pg) ^ 8'h80);
    set_bnd(int'(first_pg));
    for (int i = 0; i < 270; i++) begin
      send_frame(0);
    end
    chk("R6 saturated tally", miss_tally, 255);
    chk("R6 saturated half", tally_half, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule